// File: doc/BRIEF.md
# Serial Bus Controller Host Register Front End

This block sits between a parallel host bus and the shift engine of a byte-oriented serial bus controller. The host selects one of four byte-wide registers with a 2-bit address, qualified by a select and separate read and write strobes. Reads are combinational while the strobe is held. Writes take effect at the next rising clock edge.

The engine reports each new protocol state as a 6-bit code with a one-cycle entry strobe. It also supplies the byte it has just moved and a flag that says it is shifting. Entering any state other than idle latches the code into the status byte and captures the transferred byte into the data register. It also raises an interrupt flag, which drives the active-low interrupt pin. While the flag is up, the data register is frozen except for host writes. The host drops the flag through a control register, and that write also signals the engine to proceed.

Address 00 is shared. A read returns the status byte and a write loads a pointer into a small bank of indirect registers. Address 11 reads and writes the bank entry that the pointer selects.

Top module: `serbus_host_regs`

## Requirements
- R1: With reset asserted at a clock edge, after that edge the status byte reads F8h, irq_n is 1, the data register and eng_tx_byte are 00h, the control read is 00h, the pointer is 0 and every indirect entry is 00h.
- R2: A read at address 00 returns the status byte. Bits 7:2 hold the last non-idle code and bits 1:0 are always 0.
- R3: An eng_enter strobe with a code other than the idle code 6'h3E has three effects after that edge. The status byte becomes {code,2'b00}, irq_n goes 0, and the data register takes eng_rx_byte.
- R4: An eng_enter strobe carrying the idle code 6'h3E sets the status to F8h. It raises no interrupt and leaves the data register unchanged.
- R5: A write at address 00 loads the pointer from bits 2:0 and ignores bits 7:3. A read at address 00 still returns the status byte.
- R6: Address 11 reads and writes the indirect entry chosen by the pointer. The eight entries are independent.
- R7: A write at address 01 is accepted only while the interrupt flag is set and eng_busy is 0. A read at address 01 returns the data register, and eng_tx_byte always equals it, bit for bit: an address byte keeps its MSB in bit 7 and its direction flag in bit 0.
- R8: A data write while the interrupt flag is clear, or while eng_busy is 1, is ignored. While the flag is set, the data register changes only through accepted host writes or a non-idle capture.
- R9: A write at address 10 with bit 3 set clears the interrupt flag, so irq_n is 1 after that edge. During that write eng_go is 1 if the flag was set. A read at address 10 returns the flag in bit 3, with all other bits 0. A write with bit 3 clear has no effect.
- R10: When a non-idle eng_enter and a clearing control write arrive in the same cycle, the entry wins and the flag stays set.
- R11: host_rdata is 00h whenever host_sel and host_rd are not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 00h when not reading |
| irq_n | output | 1 | Active-low interrupt |
| eng_state | input | 6 | State code from the engine |
| eng_enter | input | 1 | State entry strobe |
| eng_rx_byte | input | 8 | Byte just moved on the bus |
| eng_busy | input | 1 | Engine is shifting |
| eng_tx_byte | output | 8 | Data register contents toward the engine |
| eng_go | output | 1 | Pulse telling the engine to proceed |

## Verification
The collision of a state entry with a clearing control write in the same cycle is the hardest case to reach from the ports, because a well-behaved engine waits for the clear. The bench drives both on one falling edge after first raising the flag. It then confirms that the interrupt stays low and that the new code and byte are latched. A data write while the flag is up but the engine reports busy is reached the same way, by holding eng_busy high through an otherwise legal write.

// File: rtl/serbus_host_pkg.sv
package serbus_host_pkg;

    localparam int BYTE_W     = 8;
    localparam int CODE_W     = 6;
    localparam int HADDR_W    = 2;
    localparam int PTR_W      = 3;
    localparam int RELEASE_IX = 3;

    localparam logic [CODE_W-1:0] IDLE_CODE = 6'h3E;

    typedef enum logic [HADDR_W-1:0] {
        RA_STAT_PTR = 2'b00,
        RA_DATA     = 2'b01,
        RA_CTRL     = 2'b10,
        RA_BANK     = 2'b11
    } reg_addr_e;

    typedef struct packed {
        logic stat_rd;
        logic ptr_wr;
        logic data_rd;
        logic data_wr;
        logic ctrl_rd;
        logic ctrl_wr;
        logic bank_rd;
        logic bank_wr;
    } host_strb_t;

    function automatic logic [BYTE_W-1:0] pack_status(input logic [CODE_W-1:0] code);
        return {code, {(BYTE_W-CODE_W){1'b0}}};
    endfunction

    function automatic logic is_active_code(input logic [CODE_W-1:0] code);
        return code != IDLE_CODE;
    endfunction

endpackage

// File: rtl/serbus_addr_decode.sv
module serbus_addr_decode
    import serbus_host_pkg::*;
(
    input  logic               sel,
    input  logic               rd,
    input  logic               wr,
    input  logic [HADDR_W-1:0] addr,
    output host_strb_t         strb
);

    reg_addr_e ra;
    assign ra = reg_addr_e'(addr);

    always_comb begin
        strb = '0;
        if (sel && rd) begin
            unique case (ra)
                RA_STAT_PTR: strb.stat_rd = 1'b1;
                RA_DATA:     strb.data_rd = 1'b1;
                RA_CTRL:     strb.ctrl_rd = 1'b1;
                RA_BANK:     strb.bank_rd = 1'b1;
                default:     ;
            endcase
        end
        if (sel && wr) begin
            unique case (ra)
                RA_STAT_PTR: strb.ptr_wr  = 1'b1;
                RA_DATA:     strb.data_wr = 1'b1;
                RA_CTRL:     strb.ctrl_wr = 1'b1;
                RA_BANK:     strb.bank_wr = 1'b1;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/serbus_status_flag.sv
module serbus_status_flag
    import serbus_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic [CODE_W-1:0] code,
    input  logic              clr_req,
    output logic              flag_q,
    output logic [BYTE_W-1:0] status_q
);

    logic raise;
    assign raise = enter && is_active_code(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= pack_status(IDLE_CODE);
        end else if (enter) begin
            status_q <= pack_status(code);
        end
    end

    // a fresh entry outranks a clear landing in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (raise) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/serbus_data_hold.sv
module serbus_data_hold
    import serbus_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic              host_ok,
    input  logic [BYTE_W-1:0] host_byte,
    output logic [BYTE_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= cap_byte;
        end else if (host_ok) begin
            data_q <= host_byte;
        end
    end

endmodule

// File: rtl/serbus_indirect_bank.sv
module serbus_indirect_bank
    import serbus_host_pkg::*;
#(
    parameter int SEL_W = PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_wr,
    input  logic              bank_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] bank_rdata
);

    localparam int DEPTH = 1 << SEL_W;

    logic [SEL_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] entry_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ptr_wr) begin
            ptr_q <= wdata[SEL_W-1:0];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (bank_wr && (ptr_q == SEL_W'(g))) begin
                entry_q[g] <= wdata;
            end
        end
    end

    assign bank_rdata = entry_q[ptr_q];

endmodule

// File: rtl/serbus_host_regs.sv
module serbus_host_regs
    import serbus_host_pkg::*;
#(
    parameter int BANK_SEL_W = PTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_sel,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata,
    output logic               irq_n,
    input  logic [CODE_W-1:0]  eng_state,
    input  logic               eng_enter,
    input  logic [BYTE_W-1:0]  eng_rx_byte,
    input  logic               eng_busy,
    output logic [BYTE_W-1:0]  eng_tx_byte,
    output logic               eng_go
);

    host_strb_t        strb;
    logic              flag_q;
    logic [BYTE_W-1:0] status_q;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] bank_rdata;
    logic [BYTE_W-1:0] ctrl_view;
    logic              clr_req;
    logic              capture;
    logic              host_ok;

    serbus_addr_decode u_dec (
        .sel  (host_sel),
        .rd   (host_rd),
        .wr   (host_wr),
        .addr (host_addr),
        .strb (strb)
    );

    assign clr_req = strb.ctrl_wr && host_wdata[RELEASE_IX];
    assign capture = eng_enter && is_active_code(eng_state);
    assign host_ok = strb.data_wr && flag_q && !eng_busy;

    serbus_status_flag u_stat (
        .clk      (clk),
        .rst      (rst),
        .enter    (eng_enter),
        .code     (eng_state),
        .clr_req  (clr_req),
        .flag_q   (flag_q),
        .status_q (status_q)
    );

    serbus_data_hold u_data (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .cap_byte  (eng_rx_byte),
        .host_ok   (host_ok),
        .host_byte (host_wdata),
        .data_q    (data_q)
    );

    serbus_indirect_bank #(
        .SEL_W (BANK_SEL_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .ptr_wr     (strb.ptr_wr),
        .bank_wr    (strb.bank_wr),
        .wdata      (host_wdata),
        .bank_rdata (bank_rdata)
    );

    always_comb begin
        ctrl_view             = '0;
        ctrl_view[RELEASE_IX] = flag_q;
    end

    always_comb begin
        host_rdata = '0;
        if (strb.stat_rd) host_rdata = status_q;
        if (strb.data_rd) host_rdata = data_q;
        if (strb.ctrl_rd) host_rdata = ctrl_view;
        if (strb.bank_rd) host_rdata = bank_rdata;
    end

    assign irq_n       = !flag_q;
    assign eng_tx_byte = data_q;
    assign eng_go      = clr_req && flag_q;

endmodule

// File: rtl/serbus_host_regs_chk.sv
module serbus_host_regs_chk
    import serbus_host_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_sel,
    input logic               host_rd,
    input logic               host_wr,
    input logic [HADDR_W-1:0] host_addr,
    input logic [BYTE_W-1:0]  host_wdata,
    input logic [BYTE_W-1:0]  host_rdata,
    input logic               irq_n,
    input logic [CODE_W-1:0]  eng_state,
    input logic               eng_enter,
    input logic [BYTE_W-1:0]  eng_tx_byte
);

    logic data_write;
    logic clear_write;
    assign data_write  = host_sel && host_wr && (host_addr == 2'b01);
    assign clear_write = host_sel && host_wr && (host_addr == 2'b10) && host_wdata[3];

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (irq_n && eng_tx_byte == 8'h00)); // R1
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst) (host_sel && host_rd && host_addr == 2'b00) |-> (host_rdata[1:0] == 2'b00)); // R2
    AST_ENTRY_RAISES: assert property (@(posedge clk) disable iff (rst) (eng_enter && eng_state != 6'h3E) |=> !irq_n); // R3
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst) (eng_enter && eng_state == 6'h3E && irq_n) |=> irq_n); // R4
    AST_CLEAR_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst) (irq_n && !eng_enter) |=> $stable(eng_tx_byte)); // R8
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst) (!irq_n && !eng_enter && !data_write) |=> $stable(eng_tx_byte)); // R8
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst) (clear_write && !(eng_enter && eng_state != 6'h3E)) |=> irq_n); // R9
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst) !(host_sel && host_rd) |-> (host_rdata == 8'h00)); // R11

endmodule

bind serbus_host_regs serbus_host_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_sel    (host_sel),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .irq_n       (irq_n),
    .eng_state   (eng_state),
    .eng_enter   (eng_enter),
    .eng_tx_byte (eng_tx_byte)
);

// File: tb/serbus_host_regs_tb.sv
module serbus_host_regs_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'b00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       irq_n;
    logic [5:0] eng_state = 6'h00;
    logic       eng_enter = 1'b0;
    logic [7:0] eng_rx_byte = 8'h00;
    logic       eng_busy = 1'b0;
    logic [7:0] eng_tx_byte;
    logic       eng_go;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serbus_host_regs u_dut (
        .clk (clk), .rst (rst),
        .host_sel (host_sel), .host_rd (host_rd), .host_wr (host_wr),
        .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
        .irq_n (irq_n),
        .eng_state (eng_state), .eng_enter (eng_enter), .eng_rx_byte (eng_rx_byte),
        .eng_busy (eng_busy), .eng_tx_byte (eng_tx_byte), .eng_go (eng_go)
    );

    typedef struct packed {
        logic [5:0] code;
        logic [7:0] rx;
        logic [7:0] wv;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{code: 6'h02, rx: 8'h11, wv: 8'hA1},
        '{code: 6'h05, rx: 8'h80, wv: 8'h01},
        '{code: 6'h10, rx: 8'hFF, wv: 8'h00},
        '{code: 6'h3F, rx: 8'h00, wv: 8'hFF},
        '{code: 6'h00, rx: 8'h5A, wv: 8'hC3},
        '{code: 6'h1C, rx: 8'h3C, wv: 8'h7E}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0;
    endtask

    task automatic enter(input logic [5:0] c, input logic [7:0] b);
        @(negedge clk);
        eng_enter = 1'b1; eng_state = c; eng_rx_byte = b;
        @(negedge clk);
        eng_enter = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 01 expected 00");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'b00, v); chk("R1 status", v, 8'hF8);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 tx", eng_tx_byte, 8'h00);
        rd(2'b10, v); chk("R1 ctrl", v, 8'h00);
        rd(2'b11, v); chk("R1 bank0", v, 8'h00);
        rd(2'b01, v); chk("R1 data", v, 8'h00);

        // R11 idle read bus
        @(negedge clk); #1 chk("R11 idle rdata", host_rdata, 8'h00);

        // R4 idle entry raises nothing
        enter(6'h3E, 8'h99);
        chk("R4 irq_n", {7'b0, irq_n}, 8'h01);
        rd(2'b00, v); chk("R4 status", v, 8'hF8);
        chk("R4 tx unchanged", eng_tx_byte, 8'h00);

        // R8 data write while flag clear is ignored
        wr(2'b01, 8'h55);
        chk("R8 ignored tx", eng_tx_byte, 8'h00);
        rd(2'b01, v); chk("R8 ignored rd", v, 8'h00);

        // vector walk: R2 R3 R7 R9
        for (int i = 0; i < 6; i++) begin
            enter(VECS[i].code, VECS[i].rx);
            chk("R3 irq_n low", {7'b0, irq_n}, 8'h00);
            rd(2'b00, v); chk("R2 R3 status", v, {VECS[i].code, 2'b00});
            rd(2'b01, v); chk("R3 captured", v, VECS[i].rx);
            rd(2'b10, v); chk("R9 ctrl view", v, 8'h08);
            wr(2'b01, VECS[i].wv);
            rd(2'b01, v); chk("R7 data rd", v, VECS[i].wv);
            chk("R7 tx byte", eng_tx_byte, VECS[i].wv);
            wr(2'b10, 8'hF7);
            chk("R9 bit3 clear no effect", {7'b0, irq_n}, 8'h00);
            @(negedge clk);
            host_sel = 1'b1; host_wr = 1'b1; host_addr = 2'b10; host_wdata = 8'h08;
            #1 chk("R9 eng_go", {7'b0, eng_go}, 8'h01);
            @(negedge clk);
            host_sel = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
            chk("R9 released", {7'b0, irq_n}, 8'h01);
            rd(2'b10, v); chk("R9 ctrl clear", v, 8'h00);
            rd(2'b01, v); chk("R8 held after clear", v, VECS[i].wv);
        end

        // R8 write blocked while busy even with flag set
        enter(6'h0A, 8'h42);
        eng_busy = 1'b1;
        wr(2'b01, 8'hEE);
        eng_busy = 1'b0;
        chk("R8 busy blocks write", eng_tx_byte, 8'h42);
        repeat (3) @(negedge clk);
        chk("R8 held while flag set", eng_tx_byte, 8'h42);

        // R10 entry and clear in the same cycle
        @(negedge clk);
        eng_enter = 1'b1; eng_state = 6'h10; eng_rx_byte = 8'h77;
        host_sel = 1'b1; host_wr = 1'b1; host_addr = 2'b10; host_wdata = 8'h08;
        @(negedge clk);
        eng_enter = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
        chk("R10 flag kept", {7'b0, irq_n}, 8'h00);
        rd(2'b00, v); chk("R10 status", v, 8'h40);
        chk("R10 byte", eng_tx_byte, 8'h77);
        wr(2'b10, 8'h08);

        // R7 address byte layout
        enter(6'h01, 8'h00);
        wr(2'b01, 8'hA1);
        chk("R7 addr msb", {7'b0, eng_tx_byte[7]}, 8'h01);
        chk("R7 rw bit", {7'b0, eng_tx_byte[0]}, 8'h01);
        wr(2'b10, 8'h08);

        // R5 R6 pointer and indirect bank
        wr(2'b00, 8'hFD);
        wr(2'b11, 8'hA5);
        wr(2'b00, 8'h02);
        wr(2'b11, 8'h3C);
        rd(2'b11, v); chk("R6 entry2", v, 8'h3C);
        wr(2'b00, 8'h05);
        rd(2'b11, v); chk("R5 R6 entry5 reserved ignored", v, 8'hA5);
        wr(2'b00, 8'h03);
        rd(2'b11, v); chk("R6 entry3 untouched", v, 8'h00);
        rd(2'b00, v); chk("R5 status not pointer", v, 8'h04);

        done = 1'b1;
        finish_run();
    end

endmodule